// File: doc/BRIEF.md
# E4 Byte-Alignment Framer

This block sits behind a deserializer that delivers an 8-bit word every byte clock with no knowledge of where byte boundaries lie in the serial E4 stream. It keeps a short history of the incoming bits. From that history it builds all eight possible byte alignments every cycle and searches them for the head of the 12-bit frame alignment word. Once it finds the head, it freezes the chosen alignment and checks the tail of the word in the next byte. After that it tracks the frame with a byte counter, so that each following alignment word is checked only at the position where it is expected.

A qualification state machine declares frame sync after three consecutive confirmed frames. It drops sync, and resumes the eight-way search, as soon as an expected alignment word is missing. Downstream logic receives the aligned byte, the frozen offset, a one-cycle strobe that marks the byte completing each confirmed alignment word, and the in-sync flag. The reset is asynchronous and active low. Its release is synchronised inside the block, which takes two byte clocks.

Top module: `e4_byte_framer`

## Requirements
- R1: Bits are taken MSB-first: bit 7 of a word is the earliest received bit. A 15-bit window holds the current word plus the seven latest bits of the previous word. With offset value k, `data_out` is the 8 window bits that start k bits after the earliest window bit, so offset 7 passes words through unchanged.
- R2: While searching, the block checks all eight alignments each cycle for the head byte 11111010. On a hit it freezes the offset at the matching alignment, and the lowest offset value wins if several alignments match.
- R3: The byte after the head at the frozen offset must have its upper four bits equal to 0000; its lower four bits are ignored. When it does, `frame_start` is high for exactly one cycle, with that byte on `data_out`, two clocks after the word that completes it enters the block.
- R4: If that tail check fails, no strobe is given and the search restarts with the byte after the failed one. The failed byte is not itself searched for a head.
- R5: `in_sync` rises together with the strobe of the third consecutive confirmed frame.
- R6: The frame period is 366 bytes (2928 bits). After a confirmation, the head is checked only at the byte position 365 bytes after the confirmed tail byte.
- R7: If the head is absent at its expected position, `in_sync` goes low in that same cycle, the byte before the missing head is still on `data_out`, and the search over all offsets resumes.
- R8: Any miss clears the count of good frames, so three further consecutive confirmed frames are needed before sync is declared again.
- R9: During reset, `data_out`, `offset`, `frame_start` and `in_sync` are all zero.
- R10: Once frozen, the offset stays unchanged until a head is found again during a search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Unaligned word from the deserializer, bit 7 earliest |
| data_out | output | 8 | Aligned byte |
| offset | output | 3 | Alignment offset in use |
| frame_start | output | 1 | One-cycle strobe with the byte completing a confirmed alignment word |
| in_sync | output | 1 | Frame sync declared |

## Verification
A word driven before clock edge n is seen by the detector after edge n, and its aligned byte, strobe and sync update appear after edge n+1. The one exception is the drop of `in_sync` on a miss, which is combinational from the window and so appears one edge earlier. The bench drives each word on a falling edge and samples on the next falling edge. It keeps two bit positions per sample: the start of the byte now shown on the output, and the start of the window the detector is examining. Expected strobes, sync and bytes are computed from these positions against the known frame position, for all eight offsets, with a corrupted frame placed both before and after sync. A directed word sequence then checks tail rejection and the restart of the search.

// File: rtl/e4fr_pkg.sv
package e4fr_pkg;
  localparam logic [7:0] FAW_HEAD   = 8'hFA;
  localparam int         FAW_TAIL_W = 4;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_CHECK  = 2'd1,
    ST_TRACK  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/e4fr_window.sv
module e4fr_window #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         din,
  output logic [W-1:0][W-1:0]  cand
);
  localparam int HW = 2*W - 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_n;

  always_comb hist_n = {hist_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  // candidate k starts k bits after the earliest window bit
  for (genvar k = 0; k < W; k++) begin : g_cand
    assign cand[k] = hist_q[HW-1-k -: W];
  end
endmodule

// File: rtl/e4fr_detect.sv
module e4fr_detect #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0][W-1:0] cand,
  output logic                hit_any,
  output logic [IW-1:0]       hit_idx
);
  import e4fr_pkg::*;

  logic [W-1:0] hit;

  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit[k] = (cand[k] == FAW_HEAD);
  end

  // lowest offset value wins
  always_comb begin
    hit_idx = '0;
    for (int k = W-1; k >= 0; k--) begin
      if (hit[k]) hit_idx = IW'(k);
    end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/e4fr_ctrl.sv
module e4fr_ctrl #(
  parameter int W           = 8,
  parameter int IW          = $clog2(W),
  parameter int FRAME_BYTES = 366,
  parameter int GOOD_FRAMES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_any,
  input  logic [IW-1:0] hit_idx,
  input  logic [W-1:0]  cur_byte,
  output logic [IW-1:0] sel,
  output logic          frame_start,
  output logic          sync_out
);
  import e4fr_pkg::*;

  localparam int CW = $clog2(FRAME_BYTES);
  localparam int GW = $clog2(GOOD_FRAMES + 1);

  fr_state_e     st_q, st_n;
  logic [IW-1:0] sel_q, sel_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [GW-1:0] good_q, good_n;
  logic          sync_q, sync_n;
  logic          fs_q;
  logic          conf, miss;

  always_comb begin
    st_n   = st_q;
    sel_n  = sel_q;
    cnt_n  = cnt_q;
    good_n = good_q;
    sync_n = sync_q;
    conf   = 1'b0;
    miss   = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (hit_any) begin
          sel_n = hit_idx;
          st_n  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cur_byte[W-1 -: FAW_TAIL_W] == '0) begin
          conf  = 1'b1;
          st_n  = ST_TRACK;
          cnt_n = '0;
          if (good_q != GW'(GOOD_FRAMES)) good_n = good_q + GW'(1);
          if (good_q >= GW'(GOOD_FRAMES - 1)) sync_n = 1'b1;
        end else begin
          miss = 1'b1;
          st_n = ST_SEARCH;
        end
      end
      ST_TRACK: begin
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == CW'(FRAME_BYTES - 2)) begin
          if (cur_byte == FAW_HEAD) begin
            st_n = ST_CHECK;
          end else begin
            miss = 1'b1;
            st_n = ST_SEARCH;
          end
        end
      end
      default: st_n = ST_SEARCH;
    endcase
    if (miss) begin
      good_n = '0;
      sync_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      sel_q  <= '0;
      cnt_q  <= '0;
      good_q <= '0;
      sync_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      sel_q  <= sel_n;
      cnt_q  <= cnt_n;
      good_q <= good_n;
      sync_q <= sync_n;
      fs_q   <= conf;
    end
  end

  assign sel         = sel_q;
  assign frame_start = fs_q;
  assign sync_out    = sync_q & ~miss;

  // R3: strobe lasts one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);
  // R10: offset frozen outside search
  a_r10_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SEARCH) |=> $stable(sel_q));
  // R8: a miss clears qualification and returns to search
  a_r8_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (good_q == '0 && !sync_q && st_q == ST_SEARCH));
  // R5: sync is only declared with a confirmed frame
  a_r5_sync_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> fs_q);
endmodule

// File: rtl/e4_byte_framer.sv
module e4_byte_framer #(
  parameter int W           = 8,
  parameter int FRAME_BYTES = 366,
  parameter int GOOD_FRAMES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         data_in,
  output logic [W-1:0]         data_out,
  output logic [$clog2(W)-1:0] offset,
  output logic                 frame_start,
  output logic                 in_sync
);
  import e4fr_pkg::*;

  localparam int IW = $clog2(W);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [W-1:0][W-1:0] cand;
  logic               hit_any;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      sel;
  logic [W-1:0]       cur_byte;
  logic [W-1:0]       dout_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  e4fr_window #(.W(W)) u_window (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (data_in),
    .cand  (cand)
  );

  e4fr_detect #(.W(W), .IW(IW)) u_detect (
    .cand    (cand),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  // shared select drives the eight one-of-eight selectors
  assign cur_byte = cand[sel];

  e4fr_ctrl #(.W(W), .IW(IW), .FRAME_BYTES(FRAME_BYTES),
              .GOOD_FRAMES(GOOD_FRAMES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit_any     (hit_any),
    .hit_idx     (hit_idx),
    .cur_byte    (cur_byte),
    .sel         (sel),
    .frame_start (frame_start),
    .sync_out    (in_sync)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dout_q <= '0;
    else             dout_q <= cur_byte;
  end

  assign data_out = dout_q;
  assign offset   = sel;

  // R3: the strobed byte carries the zero tail
  a_r3_tail_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |-> (data_out[W-1 -: FAW_TAIL_W] == '0));
endmodule

// File: tb/test_e4_byte_framer.sv
`timescale 1ns/1ps
module test_e4_byte_framer;
  localparam int FB = 2928;
  localparam int NF = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic [2:0] offset;
  logic       frame_start;
  logic       in_sync;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int p_cur;
  int bad_cur;

  always #2.5 clk = ~clk;

  e4_byte_framer i_e4_byte_framer (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_out(data_out),
    .offset(offset), .frame_start(frame_start), .in_sync(in_sync)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit bit_at(input int pos);
    int rel, f, i;
    longint h;
    if (pos < p_cur) return 1'b0;
    rel = pos - p_cur;
    f = rel / FB;
    i = rel % FB;
    if (i < 12) begin
      if (f == bad_cur && i == 1) return 1'b0;
      return (i < 5 || i == 6);
    end
    if (i % 4 == 3) return 1'b0;
    h = longint'(rel) * 64'd2654435761;
    return h[17];
  endfunction

  function automatic logic [7:0] word_at(input int start);
    logic [7:0] w;
    for (int b = 0; b < 8; b++) w[7-b] = bit_at(start + b);
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    data_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_stream(input int k, input int bad);
    int s_prev, s_cur, f, gc, nwords;
    bit locked, sync_m, fs_e, sync_e, miss_now;
    p_cur = 9 + k;
    bad_cur = bad;
    do_reset();
    gc = 0; locked = 0; sync_m = 0;
    nwords = (p_cur + NF*FB) / 8 + 1;
    for (int idx = 0; idx < nwords; idx++) begin
      @(negedge clk);
      if (idx >= 2) begin
        s_prev = 8*idx - 23 + k;
        s_cur  = s_prev + 8;
        fs_e = 1'b0;
        if (s_prev >= p_cur + 8 && (s_prev - p_cur - 8) % FB == 0) begin
          f = (s_prev - p_cur - 8) / FB;
          if (f != bad) begin
            fs_e = 1'b1;
            locked = 1'b1;
            if (gc < 3) gc++;
            if (gc >= 3) sync_m = 1'b1;
          end
        end
        miss_now = 1'b0;
        if (s_cur >= p_cur && (s_cur - p_cur) % FB == 0 &&
            (s_cur - p_cur) / FB == bad) miss_now = 1'b1;
        sync_e = sync_m & ~miss_now;
        chk("R3/R6 frame_start", int'(frame_start), int'(fs_e));
        chk(miss_now ? "R7 in_sync" : "R5/R8 in_sync", int'(in_sync), int'(sync_e));
        if (locked) begin
          chk("R2/R10 offset", int'(offset), k);
          chk("R1 data_out", int'(data_out), int'(word_at(s_prev)));
        end
        if (miss_now) begin
          sync_m = 1'b0;
          gc = 0;
        end
      end
      data_in = word_at(8*idx);
    end
  endtask

  initial begin
    logic [7:0] seq [14];
    // R9: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 data_out", int'(data_out), 0);
    chk("R9 offset", int'(offset), 0);
    chk("R9 frame_start", int'(frame_start), 0);
    chk("R9 in_sync", int'(in_sync), 0);

    // sweep all offsets; corrupted frame before or after sync
    for (int k = 0; k < 8; k++) run_stream(k, (k % 2 == 1) ? 1 : 4);

    // R4: tail rejection and search restart, offset 7 alignment
    seq = '{8'h00, 8'h00, 8'hFA, 8'h80, 8'h00, 8'h00, 8'hFA,
            8'hFA, 8'h00, 8'h00, 8'hFA, 8'h05, 8'h00, 8'h00};
    do_reset();
    for (int idx = 0; idx < 14; idx++) begin
      @(negedge clk);
      if (idx >= 2) begin
        chk("R4 frame_start", int'(frame_start), (idx == 13) ? 1 : 0);
        chk("R4 in_sync", int'(in_sync), 0);
      end
      if (idx == 13) begin
        chk("R3 data_out tail byte", int'(data_out), 8'h05);
        chk("R2 offset", int'(offset), 7);
      end
      data_in = seq[idx];
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule